// File: doc/BRIEF.md
# Dual-Mode Frequency/Period Counter

This block measures an external digital signal that arrives on one of two pins: a high-range input and a low-range input. In frequency mode it counts the rising edges of the chosen input during a gate window whose length is a whole number of reference-clock cycles. In period mode it counts reference-clock cycles across one or two full periods of the input, starting at the first rising edge seen after the measurement is started. Period mode exists only on the low-range input. With the high-range input selected, the block measures frequency whatever the mode input says.

A measurement starts when `enable` goes high. The source, mode and gate settings are captured at that moment. When the measurement ends, `done` pulses for one cycle and the result stays on `count` until `enable` is dropped. Dropping `enable` at any time aborts a measurement and clears the result. Both signal inputs pass through a synchronizer of configurable depth before their edges are detected.

Top module: `fpmeter`

## Requirements
- R1: After reset, `count` is 0 and `done` is 0.
- R2: `src_lo` = 0 selects `hi_in` and `src_lo` = 1 selects `lo_in`. Edges on the input that is not selected do not change `count`.
- R3: In frequency mode, `count` ends equal to the number of rising edges of the selected input that fall inside the gate window.
- R4: The gate window lasts GATE_TICKS cycles when `gate_long` = 0 and 2*GATE_TICKS cycles when `gate_long` = 1. Take the clock edge that first samples `enable` high as edge 0. `done` is then high in the cycle after edge GATE_TICKS (or edge 2*GATE_TICKS for the long gate).
- R5: When `src_lo` = 0, the value of `mode_period` is ignored and a frequency measurement runs.
- R6: When `src_lo` = 1 and `mode_period` = 1, `count` ends equal to the number of reference cycles between the first rising edge after start and the next rising edge (`gate_long` = 0), or the rising edge after that (`gate_long` = 1).
- R7: `count` is a CNT_W-bit binary value (bit CNT_W-1 is the MSB). It saturates at all ones instead of wrapping.
- R8: `done` is high for exactly one cycle per measurement. After `done`, `count` holds while `enable` stays high, and no further measurement starts until `enable` has gone low and then high again.
- R9: A low `enable` sampled at a clock edge aborts any measurement. `count` is 0 after that edge and no `done` is produced for the aborted measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; also the timebase for gates and periods |
| rst_n | input | 1 | Active-low asynchronous reset |
| hi_in | input | 1 | High-range signal input (frequency only) |
| lo_in | input | 1 | Low-range signal input |
| src_lo | input | 1 | Source select: 0 = hi_in, 1 = lo_in |
| mode_period | input | 1 | 1 = period mode (effective only with lo_in) |
| gate_long | input | 1 | 0 = short gate / one period, 1 = double gate / two periods |
| enable | input | 1 | High starts and keeps a measurement; low aborts and clears |
| count | output | CNT_W | Measurement result, saturating binary |
| done | output | 1 | One-cycle pulse when a measurement completes |

## Verification
A gate timer that is off by one shows up at `done` one cycle early or late. The bench counts cycles from the start edge, so the error is visible within one window. A wrong source or mode capture shows up as a wrong total: the unselected pin's pulses are added, or a period-like value appears where an edge count is expected, once the measurement completes. A counter that wraps instead of saturating, or that does not clear on abort, shows on `count` at the first cycle after overflow or after `enable` falls.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GATE,
        ST_ARM,
        ST_MEAS,
        ST_HOLD
    } fpm_state_e;
endpackage

// File: rtl/fpm_edge_sync.sv
module fpm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

    // a rise must be a single-cycle event
    p_rise_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/fpm_window.sv
module fpm_window #(
    parameter int TICKS = 600000,
    localparam int W = $clog2(2 * TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic long_win,
    output logic expire
);
    logic [W-1:0] tick_d, tick_q;
    logic [W-1:0] limit;

    always_comb begin
        limit  = long_win ? W'(2 * TICKS - 1) : W'(TICKS - 1);
        tick_d = run ? tick_q + W'(1) : '0;
        expire = run && (tick_q == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick_q <= '0;
        else        tick_q <= tick_d;
    end

    p_tick_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (tick_q <= W'(2 * TICKS - 1)));
endmodule

// File: rtl/fpmeter.sv
module fpmeter
    import fpm_pkg::*;
#(
    parameter int CNT_W       = 20,
    parameter int GATE_TICKS  = 600000,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hi_in,
    input  logic             lo_in,
    input  logic             src_lo,
    input  logic             mode_period,
    input  logic             gate_long,
    input  logic             enable,
    output logic [CNT_W-1:0] count,
    output logic             done
);
    typedef struct packed {
        fpm_state_e       state;
        logic             cfg_lo;
        logic             cfg_long;
        logic             periods;
        logic [CNT_W-1:0] count;
        logic             done;
    } meas_t;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    meas_t m_d, m_q;
    logic  hi_rise, lo_rise, sel_rise, expire;
    logic  [CNT_W-1:0] bumped;

    fpm_edge_sync #(.STAGES(SYNC_STAGES)) u_hi_sync (
        .clk(clk), .rst_n(rst_n), .din(hi_in), .rise(hi_rise));

    fpm_edge_sync #(.STAGES(SYNC_STAGES)) u_lo_sync (
        .clk(clk), .rst_n(rst_n), .din(lo_in), .rise(lo_rise));

    fpm_window #(.TICKS(GATE_TICKS)) u_window (
        .clk(clk), .rst_n(rst_n),
        .run(m_q.state == ST_GATE),
        .long_win(m_q.cfg_long),
        .expire(expire));

    always_comb begin
        sel_rise = m_q.cfg_lo ? lo_rise : hi_rise;
        bumped   = (m_q.count == CNT_MAX) ? m_q.count : m_q.count + CNT_W'(1);
        m_d      = m_q;
        m_d.done = 1'b0;
        if (!enable) begin
            m_d = '{state: ST_IDLE, cfg_lo: 1'b0, cfg_long: 1'b0,
                    periods: 1'b0, count: '0, done: 1'b0};
        end else begin
            unique case (m_q.state)
                ST_IDLE: begin
                    m_d.cfg_lo   = src_lo;
                    m_d.cfg_long = gate_long;
                    m_d.periods  = 1'b0;
                    m_d.count    = '0;
                    m_d.state    = (src_lo && mode_period) ? ST_ARM : ST_GATE;
                end
                ST_GATE: begin
                    if (sel_rise) m_d.count = bumped;
                    if (expire) begin
                        m_d.state = ST_HOLD;
                        m_d.done  = 1'b1;
                    end
                end
                ST_ARM: begin
                    if (sel_rise) begin
                        m_d.state = ST_MEAS;
                        m_d.count = '0;
                    end
                end
                ST_MEAS: begin
                    m_d.count = bumped;
                    if (sel_rise) begin
                        if (!m_q.cfg_long || m_q.periods) begin
                            m_d.state = ST_HOLD;
                            m_d.done  = 1'b1;
                        end else begin
                            m_d.periods = 1'b1;
                        end
                    end
                end
                ST_HOLD: begin
                end
                default: m_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '{state: ST_IDLE, cfg_lo: 1'b0, cfg_long: 1'b0,
                     periods: 1'b0, count: '0, done: 1'b0};
        end else begin
            m_q <= m_d;
        end
    end

    assign count = m_q.count;
    assign done  = m_q.done;

    p_abort_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (count == '0 && !done));

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_q.state == ST_HOLD && enable) |=> $stable(count));

    p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_MAX && enable) |=> (count == CNT_MAX));

    p_period_low_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_q.state == ST_ARM || m_q.state == ST_MEAS) |-> m_q.cfg_lo);
endmodule

// File: tb/tb_fpmeter.sv
module tb_fpmeter;
    localparam int GT = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hi_in = 1'b0, lo_in = 1'b0;
    logic src_lo = 1'b0, mode_period = 1'b0, gate_long = 1'b0, enable = 1'b0;
    logic [19:0] count;
    logic        done;
    logic [3:0]  count_s;
    logic        done_s;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fpmeter #(.CNT_W(20), .GATE_TICKS(GT)) dut (
        .clk(clk), .rst_n(rst_n), .hi_in(hi_in), .lo_in(lo_in),
        .src_lo(src_lo), .mode_period(mode_period), .gate_long(gate_long),
        .enable(enable), .count(count), .done(done));

    fpmeter #(.CNT_W(4), .GATE_TICKS(GT)) dut_sat (
        .clk(clk), .rst_n(rst_n), .hi_in(hi_in), .lo_in(lo_in),
        .src_lo(src_lo), .mode_period(mode_period), .gate_long(gate_long),
        .enable(enable), .count(count_s), .done(done_s));

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulses(input bit on_lo, input int n, input int hi_c, input int lo_c);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); if (on_lo) lo_in = 1'b1; else hi_in = 1'b1;
            repeat (hi_c - 1) @(negedge clk);
            @(negedge clk); if (on_lo) lo_in = 1'b0; else hi_in = 1'b0;
            repeat (lo_c - 1) @(negedge clk);
        end
    endtask

    task automatic wait_done(output int dt, output int ndone, input int t0, input int lim);
        ndone = 0; dt = -1;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (done) begin
                if (ndone == 0) dt = cyc - t0;
                ndone++;
            end
        end
    endtask

    task automatic start(input bit s, input bit m, input bit g, output int t0);
        @(negedge clk);
        src_lo = s; mode_period = m; gate_long = g; enable = 1'b1;
        t0 = cyc;
    endtask

    task automatic stop();
        @(negedge clk); enable = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 count", count, 0);
        check("R1 done", done, 0);
    endtask

    task automatic t_hi_forced();
        int t0, dt, nd;
        start(1'b0, 1'b1, 1'b0, t0);
        fork
            begin repeat (3) @(negedge clk); pulses(1'b0, 5, 2, 3); end
            begin repeat (3) @(negedge clk); pulses(1'b1, 3, 3, 3); end
            wait_done(dt, nd, t0, GT + 20);
        join
        check("R4 short window timing", dt, GT + 1);
        check("R5 hi forces frequency count", count, 5);
        check("R2 hi selected ignores lo", count, 5);
        check("R8 single done", nd, 1);
        stop();
    endtask

    task automatic t_lo_freq_long();
        int t0, dt, nd;
        start(1'b1, 1'b0, 1'b1, t0);
        fork
            begin repeat (3) @(negedge clk); pulses(1'b1, 12, 2, 2); end
            begin repeat (3) @(negedge clk); pulses(1'b0, 4, 2, 2); end
            wait_done(dt, nd, t0, 2 * GT + 20);
        join
        check("R4 long window timing", dt, 2 * GT + 1);
        check("R3 lo frequency count", count, 12);
        check("R2 lo selected ignores hi", count, 12);
        // R8: after done, more edges and time must not change the result
        pulses(1'b1, 4, 2, 2);
        repeat (10) @(negedge clk);
        check("R8 hold after done", count, 12);
        stop();
    endtask

    task automatic t_period(input bit g, input int per, input int exp);
        int t0, dt, nd;
        start(1'b1, 1'b1, g, t0);
        fork
            begin repeat (3) @(negedge clk); pulses(1'b1, 5, per / 2, per - per / 2); end
            wait_done(dt, nd, t0, 6 * per + 20);
        join
        check(g ? "R6 two periods" : "R6 one period", count, exp);
        check("R8 period single done", nd, 1);
        stop();
    endtask

    task automatic t_saturate();
        int t0, dt, nd;
        start(1'b0, 1'b0, 1'b1, t0);
        fork
            begin repeat (3) @(negedge clk); pulses(1'b0, 19, 2, 1); end
            wait_done(dt, nd, t0, 2 * GT + 20);
        join
        check("R3 19 edges wide counter", count, 19);
        check("R7 narrow counter saturates", count_s, 15);
        stop();
    endtask

    task automatic t_abort();
        int t0, dt, nd;
        start(1'b0, 1'b0, 1'b1, t0);
        repeat (3) @(negedge clk);
        pulses(1'b0, 3, 2, 2);
        @(negedge clk);
        check("R3 partial count before abort", count, 3);
        enable = 1'b0;
        @(negedge clk);
        check("R9 abort clears count", count, 0);
        wait_done(dt, nd, t0, 2 * GT + 10);
        check("R9 no done after abort", nd, 0);
        stop();
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_hi_forced();
        t_lo_freq_long();
        t_period(1'b0, 10, 10);
        t_period(1'b1, 7, 14);
        t_saturate();
        t_abort();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule